// File: doc/BRIEF.md
# Watchdog-Capable Interval Timer Channel

This block is one timer channel. A 16-bit up-counter advances on a prescaled tick, and two compare registers raise sticky match flags. Through a separate reset-enable control bit, the channel can act as a system watchdog. The tick source is either an external slow tick strobe, nominally 32 kHz, or the block's own clock. A power-of-two prescaler divides that source. With a divide-by-8192 setting on the slow tick, the counter advances at 4 Hz.

Software claims the channel by writing its setup register. That first write fixes the prescaler, the tick source and the compare enables until the next hardware reset. After it, only the run bit and the two write-one-to-clear event bits respond. A setup register that reads zero marks a channel nobody has claimed yet.

For watchdog use, software loads compare 2 with the timeout and sets the reset-enable bit. It then reloads the counter periodically with this order of writes: stop the count, drop reset-enable, write the counter, clear the flags, restore reset-enable, restart the count. If the counter reaches compare 2 first, the block pulses its reset request.

Top module: `gpt_wdog_timer`

## Requirements
- R1: After reset every register reads zero and the reset request is low.
- R2: The first setup write (address 3) stores the prescale exponent in bits [3:0], the tick source in bit 4 (1 = every clock, 0 = slow tick input), the compare-1 enable in bit 5, the compare-2 enable in bit 6 and the run bit in bit 15. It also sets the read-only claimed bit 14, so a claimed channel never reads zero.
- R3: Once claimed, a setup write changes only run (bit 15) and the event-clear bits (12, 13). Bits [6:0] keep the values from the first write.
- R4: While run is 1, the counter advances once per 2^n source ticks, where n is the prescale exponent. While run is 0 it holds its value.
- R5: With tick source 0, the counter advances only on pulses of the slow tick input.
- R6: A write to the count register (address 2) loads the counter directly and restarts the prescaler phase. The counter wraps from 0xFFFF to 0x0000.
- R7: Compare registers sit at address 0 (compare 1) and address 1 (compare 2). An event flag (setup bit 12 for compare 1, bit 13 for compare 2) sets in the cycle after the counter equals its compare value, but only when that compare's enable bit is set. The flag stays set afterwards.
- R8: A setup write with a 1 in bit 12 or 13 clears that flag, and a 0 there leaves it alone. A match in the same cycle as a clear wins.
- R9: Reset-enable is bit 0 at address 4. The reset request is a one-cycle pulse, raised together with the compare-2 flag only when that flag rises while reset-enable is 1. Raising reset-enable while the flag is already set gives no pulse.
- R10: The full reload sequence gives no pulse while it runs and restarts the count from the loaded value. A later timeout pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| tick_32k | input | 1 | Slow tick strobe, one clock wide per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the lock. A later write that carries random configuration bits must leave the first setup in place. A design that relocked on every write would change its prescale rate or compare modes. The reset pulse is timed to the exact cycle after the counter reaches compare 2 and must be one cycle wide. A level-style output, or a pulse taken from the flag level instead of its rising edge, would fire again when reset-enable is raised over a flag that is already set. The bench also runs the counter across 0xFFFF, runs the slow-tick path with a divider, and sends an event-clear write with a 0 bit. A design that cleared both flags on any setup write, or that lost the count while stopped, would show up in these readbacks.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 4;

    localparam logic [ADDR_W-1:0] A_CMP1   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP2   = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SETUP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RSTCTL = 3'd4;

    localparam int B_SRC    = 4;
    localparam int B_C1EN   = 5;
    localparam int B_C2EN   = 6;
    localparam int B_EV1    = 12;
    localparam int B_EV2    = 13;
    localparam int B_CLAIM  = 14;
    localparam int B_RUN    = 15;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             src_fast;
        logic             c1_en;
        logic             c2_en;
    } gpt_cfg_t;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PC_W = (1 << DIV_W) - 1;

    logic [PC_W-1:0] pc_q, pc_d, mask;

    always_comb begin
        for (int i = 0; i < PC_W; i++) begin
            mask[i] = (i < int'(div));
        end
        tick = run && src_tick && ((pc_q & mask) == mask);
        pc_d = pc_q;
        if (!run || restart) begin
            pc_d = '0;
        end else if (src_tick) begin
            pc_d = pc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // a prescaled tick only comes from an enabled source tick
    assert_tick_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run && src_tick));
endmodule

// File: rtl/gpt_event_flag.sv
module gpt_event_flag #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] match_val,
    input  logic             arm,
    input  logic             clr,
    output logic             flag,
    output logic             rise
);
    logic flag_q, flag_d, hit;

    always_comb begin
        hit    = arm && (count == match_val);
        flag_d = hit || (flag_q && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
    assign rise = hit && !flag_q;

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr && !arm) |=> !flag_q);
endmodule

// File: rtl/gpt_wdog_timer.sv
module gpt_wdog_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              rst_req
);
    localparam int NCMP = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cmp1;
        logic [CNT_W-1:0] cmp2;
        logic [CNT_W-1:0] count;
        gpt_cfg_t         cfg;
        logic             claimed;
        logic             run;
        logic             rst_en;
        logic             rst_req;
    } gpt_state_t;

    gpt_state_t st_q, st_d;

    logic             wr_setup, wr_count, src_tick, tick;
    logic [NCMP-1:0]  flag, rise, arm, clr;
    logic [CNT_W-1:0] cmp_val [NCMP];

    assign wr_setup = bus_wr && (bus_addr == A_SETUP);
    assign wr_count = bus_wr && (bus_addr == A_COUNT);
    assign src_tick = st_q.cfg.src_fast ? 1'b1 : tick_32k;

    gpt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.run),
        .restart  (wr_count),
        .src_tick (src_tick),
        .div      (st_q.cfg.div),
        .tick     (tick)
    );

    assign cmp_val[0] = st_q.cmp1;
    assign cmp_val[1] = st_q.cmp2;
    assign arm        = {st_q.cfg.c2_en, st_q.cfg.c1_en};
    assign clr        = {wr_setup && bus_wdata[B_EV2], wr_setup && bus_wdata[B_EV1]};

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        gpt_event_flag #(.CNT_W(CNT_W)) u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (st_q.count),
            .match_val (cmp_val[gi]),
            .arm       (arm[gi]),
            .clr       (clr[gi]),
            .flag      (flag[gi]),
            .rise      (rise[gi])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CMP1:   st_d.cmp1   = bus_wdata;
                A_CMP2:   st_d.cmp2   = bus_wdata;
                A_RSTCTL: st_d.rst_en = bus_wdata[0];
                A_SETUP: begin
                    st_d.run = bus_wdata[B_RUN];
                    if (!st_q.claimed) begin
                        st_d.claimed      = 1'b1;
                        st_d.cfg.div      = bus_wdata[DIV_W-1:0];
                        st_d.cfg.src_fast = bus_wdata[B_SRC];
                        st_d.cfg.c1_en    = bus_wdata[B_C1EN];
                        st_d.cfg.c2_en    = bus_wdata[B_C2EN];
                    end
                end
                default: ;
            endcase
        end
        if (wr_count)  st_d.count = bus_wdata;
        else if (tick) st_d.count = st_q.count + 1'b1;
        st_d.rst_req = rise[1] && st_q.rst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CMP1:   bus_rdata = st_q.cmp1;
            A_CMP2:   bus_rdata = st_q.cmp2;
            A_COUNT:  bus_rdata = st_q.count;
            A_RSTCTL: bus_rdata[0] = st_q.rst_en;
            A_SETUP: begin
                bus_rdata[DIV_W-1:0] = st_q.cfg.div;
                bus_rdata[B_SRC]     = st_q.cfg.src_fast;
                bus_rdata[B_C1EN]    = st_q.cfg.c1_en;
                bus_rdata[B_C2EN]    = st_q.cfg.c2_en;
                bus_rdata[B_EV1]     = flag[0];
                bus_rdata[B_EV2]     = flag[1];
                bus_rdata[B_CLAIM]   = st_q.claimed;
                bus_rdata[B_RUN]     = st_q.run;
            end
            default: ;
        endcase
    end

    assign rst_req = st_q.rst_req;

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> !st_q.rst_req);
    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |-> (flag[1] && $past(st_q.rst_en)));
    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.claimed |=> $stable(st_q.cfg));
    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_count) |=> $stable(st_q.count));
endmodule

// File: tb/gpt_wdog_timer_tb_top.sv
module gpt_wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int wide = 0;
    logic prev_req = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    gpt_wdog_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    always @(negedge clk) begin
        if (rst_n && rst_req) pulses++;
        if (rst_n && rst_req && prev_req) wide++;
        prev_req = rst_req;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; tick_32k = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [15:0] sw(input bit run, input bit ev2, input bit ev1,
                                       input bit c2, input bit c1, input bit src,
                                       input logic [3:0] div);
        logic [15:0] w = '0;
        w[15] = run; w[13] = ev2; w[12] = ev1;
        w[6] = c2; w[5] = c1; w[4] = src; w[3:0] = div;
        return w;
    endfunction

    function automatic logic [15:0] exp_count(input int n, input int d);
        return 16'(n >> d);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int p0;
        void'($urandom(32'h5eed));

        // R1 reset state
        do_reset();
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reg zero", v, 16'h0);
        end
        check("R1 rst_req low", {15'b0, rst_req}, 16'h0);

        // R2 / R4 / R3 random prescale and lock
        for (int k = 0; k < 12; k++) begin
            int d, n;
            logic [15:0] w1, w2;
            do_reset();
            d = int'($urandom_range(0, 4));
            n = int'($urandom_range(1, 120));
            w1 = sw(1, 0, 0, 1'($urandom), 1'($urandom), 1, 4'(d));
            wr(3'd3, w1);
            rd(3'd3, v);
            check("R2 setup claimed", v & 16'hC07F, (w1 & 16'h807F) | 16'h4000);
            repeat (n) @(negedge clk);
            rd(3'd2, v);
            check("R4 prescaled count", v, exp_count(n, d));
            w2 = 16'($urandom);
            wr(3'd3, w2);
            rd(3'd3, v);
            check("R3 locked fields", v & 16'hC07F,
                  (w2 & 16'h8000) | 16'h4000 | (w1 & 16'h007F));
        end

        // R6 wrap, direct load; R4 hold
        do_reset();
        wr(3'd3, sw(1, 0, 0, 0, 0, 1, 0));
        wr(3'd2, 16'hFFFE);
        repeat (2) @(negedge clk);
        rd(3'd2, v);
        check("R6 wrap", v, 16'h0000);
        wr(3'd3, sw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd2, 16'h1234);
        rd(3'd2, v);
        check("R6 load", v, 16'h1234);
        repeat (20) @(negedge clk);
        rd(3'd2, v);
        check("R4 hold while stopped", v, 16'h1234);

        // R5 slow tick source, divide by 2
        do_reset();
        wr(3'd3, sw(1, 0, 0, 0, 0, 0, 4'd1));
        repeat (10) @(negedge clk);
        rd(3'd2, v);
        check("R5 no tick no count", v, 16'h0);
        for (int p = 0; p < 6; p++) begin
            @(negedge clk); tick_32k = 1'b1;
            @(negedge clk); tick_32k = 1'b0;
            repeat (2) @(negedge clk);
            if (p == 2) begin
                rd(3'd2, v);
                check("R5 three ticks", v, 16'd1);
            end
        end
        rd(3'd2, v);
        check("R5 six ticks", v, 16'd3);

        // R7 compare mode: compare 1 armed, compare 2 not
        do_reset();
        wr(3'd1, 16'd4);
        wr(3'd4, 16'd1);
        p0 = pulses;
        wr(3'd3, sw(1, 0, 0, 0, 1, 1, 0));
        repeat (8) @(negedge clk);
        rd(3'd3, v);
        check("R7 flag1 set", {15'b0, v[12]}, 16'd1);
        check("R7 unarmed flag2 clear", {15'b0, v[13]}, 16'd0);
        check("R9 no pulse unarmed", 16'(pulses - p0), 16'd0);

        // R9 timed pulse, R8 clear, R10 reload
        do_reset();
        wr(3'd1, 16'd10);
        wr(3'd4, 16'd1);
        p0 = pulses;
        wr(3'd3, sw(1, 0, 0, 1, 0, 1, 0));
        repeat (10) @(negedge clk);
        rd(3'd2, v);
        check("R7 count at compare", v, 16'd10);
        check("R9 no early pulse", {15'b0, rst_req}, 16'd0);
        @(negedge clk);
        check("R9 pulse high", {15'b0, rst_req}, 16'd1);
        rd(3'd3, v);
        check("R7 flag2 with pulse", {15'b0, v[13]}, 16'd1);
        @(negedge clk);
        check("R9 pulse one cycle", {15'b0, rst_req}, 16'd0);
        wr(3'd3, sw(1, 0, 0, 0, 0, 0, 0));
        rd(3'd3, v);
        check("R8 zero leaves flag", {15'b0, v[13]}, 16'd1);
        wr(3'd3, sw(1, 1, 0, 0, 0, 0, 0));
        rd(3'd3, v);
        check("R8 one clears flag", {15'b0, v[13]}, 16'd0);
        wr(3'd3, sw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd4, 16'd0);
        wr(3'd2, 16'd0);
        wr(3'd3, sw(0, 1, 1, 0, 0, 0, 0));
        wr(3'd4, 16'd1);
        wr(3'd3, sw(1, 0, 0, 0, 0, 0, 0));
        check("R10 no pulse in reload", 16'(pulses - p0), 16'd1);
        repeat (5) @(negedge clk);
        rd(3'd2, v);
        check("R10 restart count", v, 16'd5);
        repeat (7) @(negedge clk);
        check("R10 second timeout pulse", 16'(pulses - p0), 16'd2);

        // R9 gate: flag rises with reset-enable clear, then enable raised
        do_reset();
        wr(3'd1, 16'd5);
        p0 = pulses;
        wr(3'd3, sw(1, 0, 0, 1, 0, 1, 0));
        repeat (8) @(negedge clk);
        rd(3'd3, v);
        check("R9 flag without enable", {15'b0, v[13]}, 16'd1);
        wr(3'd4, 16'd1);
        repeat (4) @(negedge clk);
        check("R9 no pulse gated", 16'(pulses - p0), 16'd0);
        check("R9 width", 16'(wide), 16'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule